// File: doc/BRIEF.md
# Digital FLL Lock Controller

This block closes the digital half of a frequency-locked loop. A slow reference clock of nominally 32.768 kHz and a fast oscillator output both arrive asynchronously. The block brings each one into the system clock domain and counts how many oscillator rising edges fall inside one reference period. It compares that count with a fixed multiplier of 306, which gives a target of about 10.027 MHz. After each period it nudges a digital trim code, which feeds an external controlled oscillator, one step toward the target. A larger trim code makes the oscillator faster.

A lock-enable input starts the process. The controller first spends a bounded warm-up interval. During warm-up the oscillator runs and is trimmed, but lock may not be declared. The controller then declares lock once enough consecutive counts fall within ±5% of the target, and withdraws it when the counts drift out of that band. With the defaults, locking takes on the order of 64 reference periods or less. Dropping lock-enable clears the lock flag at once and freezes the trim code until the controller is enabled again.

The control state machine has four states:
- `ST_IDLE`: disabled, trim frozen.
- `ST_WARM`: warm-up, trimming, lock barred.
- `ST_ACQ`: acquiring, counting in-band periods.
- `ST_LOCK`: locked, counting out-of-band periods.

Its transitions are:
- `enable`: `ST_IDLE`→`ST_WARM` when lock-enable is high.
- `warm_done`: `ST_WARM`→`ST_ACQ` on the last warm-up measurement.
- `lock_gain`: `ST_ACQ`→`ST_LOCK` on the LOCK_RUN-th consecutive in-band measurement.
- `lock_loss`: `ST_LOCK`→`ST_ACQ` on the UNLOCK_RUN-th consecutive out-of-band measurement.
- `disable`: any state→`ST_IDLE` when lock-enable is low.

Top module: `fll_lock_ctrl`

## Requirements
- R1: While reset is asserted, `trim_code` equals TRIM_INIT (2**(TRIM_W-1) by default) and `locked` is 0.
- R2: Measurement and step direction. A measurement is the number of oscillator rising edges between two consecutive synchronized reference rising edges. The first reference edge after enabling only opens a window. A measurement below 306-DEADBAND raises the trim code by one. A measurement above 306+DEADBAND lowers it by one. A measurement inside the deadband (DEADBAND=1) leaves it unchanged.
- R3: The trim code changes by at most one step per reference period.
- R4: The trim code saturates: it stays at 0 when asked to go lower, and at 2**TRIM_W-1 when asked to go higher.
- R5: After lock-enable rises, the first WARMUP_REFS (default 8) measurements can never cause `locked` to assert.
- R6: After warm-up, `locked` asserts on the LOCK_RUN-th (default 4) consecutive measurement within tolerance. Tolerance is 306 ± 306*5/100, that is 291 to 321 inclusive.
- R7: A single out-of-tolerance measurement while locked does not clear `locked`.
- R8: `locked` clears on the UNLOCK_RUN-th (default 2) consecutive out-of-tolerance measurement.
- R9: When `lock_en` is 0, `locked` is 0 in the same cycle.
- R10: While `lock_en` is 0, the trim code does not change, whatever the oscillator does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples both input clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_en | input | 1 | Starts locking when high; disables and freezes when low |
| ref_clk | input | 1 | Asynchronous reference clock (nominally 32.768 kHz) |
| osc_clk | input | 1 | Asynchronous output of the controlled oscillator |
| trim_code | output | TRIM_W | Trim code for the controlled oscillator; larger is faster |
| locked | output | 1 | High while the oscillator is locked to the reference |

## Verification
The bench models the oscillator as a frequency that is linear in the trim code, plus a settable offset. It then drives the loop with five offset patterns:
- An offset that starts 20 counts fast shows that the code moves downward one step per period and that the warm-up and the four-good rule decide the exact lock period.
- A one-period fast burst separates the single-outlier tolerance from real loss.
- A sustained fast shift shows loss after exactly two bad periods, followed by relock.
- Offsets too fast and too slow for any code drive the code into both saturation limits.
- A far-off offset applied while disabled shows whether the trim code stays frozen.

// File: rtl/fll_pkg.sv
package fll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WARM = 2'd1,
        ST_ACQ  = 2'd2,
        ST_LOCK = 2'd3
    } fll_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fll_edge_sync.sv
module fll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] sync_q;
    logic         last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[MSB-1:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[MSB];
    end

    assign rise_o = sync_q[MSB] & ~last_q;

endmodule

// File: rtl/fll_period_counter.sv
module fll_period_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             osc_rise_i,
    input  logic             ref_rise_i,
    output logic [CNT_W-1:0] meas_o,
    output logic             meas_vld_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;

    // free-running edge counter, restarted by each reference edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ref_rise_i) begin
            cnt_q <= osc_rise_i ? CNT_W'(1) : '0;
        end else if (osc_rise_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // first reference edge after arming only opens a window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          primed_q <= 1'b0;
        else if (!arm_i)     primed_q <= 1'b0;
        else if (ref_rise_i) primed_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_o     <= '0;
            meas_vld_o <= 1'b0;
        end else begin
            meas_vld_o <= ref_rise_i & primed_q & arm_i;
            if (ref_rise_i) meas_o <= cnt_q;
        end
    end

    // R2: the count never wraps inside a window
    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_rise_i && !ref_rise_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R2: a measurement is only offered after the window was primed
    assert_primed_meas_R2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld_o |-> $past(primed_q));

endmodule

// File: rtl/fll_trim_stepper.sv
module fll_trim_stepper #(
    parameter int TRIM_W    = 8,
    parameter int TRIM_INIT = 2 ** (TRIM_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en_i,
    input  logic              step_up_i,
    input  logic              step_dn_i,
    output logic [TRIM_W-1:0] trim_o
);
    localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};
    localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(TRIM_INIT);

    logic [TRIM_W-1:0] trim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_q <= TRIM_RST;
        end else if (step_en_i) begin
            if (step_up_i && trim_q != TRIM_MAX)
                trim_q <= trim_q + 1'b1;
            else if (step_dn_i && trim_q != '0)
                trim_q <= trim_q - 1'b1;
        end
    end

    assign trim_o = trim_q;

    // R3: any change of the code is caused by a step request
    assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_q != $past(trim_q)) |-> $past(step_en_i));

    // R4: saturation at the top
    assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && step_up_i && trim_q == TRIM_MAX) |=> (trim_q == TRIM_MAX));

    // R4: saturation at the bottom
    assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && step_dn_i && !step_up_i && trim_q == '0) |=> (trim_q == '0));

endmodule

// File: rtl/fll_lock_ctrl.sv
module fll_lock_ctrl #(
    parameter int TARGET      = 306,
    parameter int TOL_PCT     = 5,
    parameter int DEADBAND    = 1,
    parameter int TRIM_W      = 8,
    parameter int TRIM_INIT   = 2 ** (TRIM_W - 1),
    parameter int WARMUP_REFS = 8,
    parameter int LOCK_RUN    = 4,
    parameter int UNLOCK_RUN  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_en,
    input  logic              ref_clk,
    input  logic              osc_clk,
    output logic [TRIM_W-1:0] trim_code,
    output logic              locked
);
    import fll_pkg::*;

    localparam int TOL     = TARGET * TOL_PCT / 100;
    localparam int RUN_MAX = max3(WARMUP_REFS, LOCK_RUN, UNLOCK_RUN);
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    localparam logic [CNT_W-1:0] TOL_LO  = CNT_W'(TARGET - TOL);
    localparam logic [CNT_W-1:0] TOL_HI  = CNT_W'(TARGET + TOL);
    localparam logic [CNT_W-1:0] BAND_LO = CNT_W'(TARGET - DEADBAND);
    localparam logic [CNT_W-1:0] BAND_HI = CNT_W'(TARGET + DEADBAND);

    localparam logic [RUN_W-1:0] WARM_LAST   = RUN_W'(WARMUP_REFS - 1);
    localparam logic [RUN_W-1:0] LOCK_LAST   = RUN_W'(LOCK_RUN - 1);
    localparam logic [RUN_W-1:0] UNLOCK_LAST = RUN_W'(UNLOCK_RUN - 1);

    logic             ref_rise, osc_rise;
    logic [CNT_W-1:0] meas;
    logic             meas_vld;
    logic             in_tol, too_slow, too_fast;
    logic             step_en;

    fll_state_e       state_q, state_d;
    logic [RUN_W-1:0] warm_q, good_q, bad_q;

    fll_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ref_clk),
        .rise_o  (ref_rise)
    );

    fll_edge_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (osc_clk),
        .rise_o  (osc_rise)
    );

    fll_period_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (lock_en),
        .osc_rise_i (osc_rise),
        .ref_rise_i (ref_rise),
        .meas_o     (meas),
        .meas_vld_o (meas_vld)
    );

    // measurement classification
    always_comb begin
        in_tol   = (meas >= TOL_LO) && (meas <= TOL_HI);
        too_slow = (meas < BAND_LO);
        too_fast = (meas > BAND_HI);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!lock_en) begin
            state_d = ST_IDLE;                              // disable
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_WARM;                 // enable
                ST_WARM: if (meas_vld && warm_q == WARM_LAST)
                             state_d = ST_ACQ;              // warm_done
                ST_ACQ:  if (meas_vld && in_tol && good_q == LOCK_LAST)
                             state_d = ST_LOCK;             // lock_gain
                ST_LOCK: if (meas_vld && !in_tol && bad_q == UNLOCK_LAST)
                             state_d = ST_ACQ;              // lock_loss
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // run counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
            good_q <= '0;
            bad_q  <= '0;
        end else begin
            if (state_q != ST_WARM || !lock_en) warm_q <= '0;
            else if (meas_vld)                  warm_q <= warm_q + 1'b1;

            if (state_q != ST_ACQ || !lock_en)  good_q <= '0;
            else if (meas_vld)                  good_q <= in_tol ? good_q + 1'b1 : '0;

            if (state_q != ST_LOCK || !lock_en) bad_q  <= '0;
            else if (meas_vld)                  bad_q  <= in_tol ? '0 : bad_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        locked  = lock_en && (state_q == ST_LOCK);
        step_en = meas_vld && lock_en && (state_q != ST_IDLE);
    end

    fll_trim_stepper #(.TRIM_W(TRIM_W), .TRIM_INIT(TRIM_INIT)) u_stepper (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en_i (step_en),
        .step_up_i (too_slow),
        .step_dn_i (too_fast),
        .trim_o    (trim_code)
    );

    // R5: acquisition is entered only after the full warm-up count
    assert_warm_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQ && $past(state_q) == ST_WARM) |-> ($past(warm_q) == WARM_LAST));

    // R6: lock is only reached from acquisition after the good run
    assert_lock_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_LOCK) |-> ($past(state_q) == ST_ACQ && $past(good_q) == LOCK_LAST));

    // R8: lock is left for acquisition only after the bad run
    assert_lock_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQ && $past(state_q) == ST_LOCK) |-> ($past(bad_q) == UNLOCK_LAST));

    // R9: a low enable sends the machine to idle
    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_en |=> (state_q == ST_IDLE));

    // R10: the trim code holds while disabled
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_en |=> $stable(trim_code));

endmodule

// File: tb/tb_fll_lock_ctrl.sv
`timescale 1ns/1ps
module tb_fll_lock_ctrl;

    localparam int TRIM_W    = 5;
    localparam int TRIM_INIT = 16;
    localparam int TARGET    = 306;
    localparam int TOL       = TARGET * 5 / 100;
    localparam int WARM      = 8;
    localparam int LRUN      = 4;
    localparam int REF_CYC   = 1024;
    localparam int TRIM_MAX  = (1 << TRIM_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lock_en = 1'b0;
    logic              ref_clk = 1'b0;
    logic              osc_clk = 1'b0;
    logic [TRIM_W-1:0] trim_code;
    logic              locked;

    int  n_total = 0;
    int  n_bad   = 0;
    bit  ended   = 1'b0;
    real osc_base = 262.0;
    int  ref_ctr = 0;

    fll_lock_ctrl #(
        .TRIM_W      (TRIM_W),
        .TRIM_INIT   (TRIM_INIT),
        .WARMUP_REFS (WARM),
        .LOCK_RUN    (LRUN)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_en   (lock_en),
        .ref_clk   (ref_clk),
        .osc_clk   (osc_clk),
        .trim_code (trim_code),
        .locked    (locked)
    );

    always #4 clk = ~clk;

    // reference: 1024 system clocks per period, changed at falling edges
    always @(negedge clk) begin
        ref_ctr = (ref_ctr == REF_CYC - 1) ? 0 : ref_ctr + 1;
        ref_clk = (ref_ctr < REF_CYC / 2);
    end

    // oscillator model: edges per reference period = base + 4 * trim
    function automatic real edges_of(input int t);
        return osc_base + 4.0 * t;
    endfunction

    initial begin
        forever begin
            #(4096.0 / edges_of(int'(trim_code)));
            osc_clk = ~osc_clk;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(posedge ref_clk);
        repeat (20) @(negedge clk);
    endtask

    function automatic bit in_band(input int t);
        real e;
        e = edges_of(t);
        return (e >= TARGET - TOL) && (e <= TARGET + TOL);
    endfunction

    task automatic t_reset;
        repeat (5) @(negedge clk);
        check(int'(trim_code) == TRIM_INIT, "R1 trim in reset", int'(trim_code), TRIM_INIT);
        check(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        rst_n = 1'b1;
        wait_ref(2);
        // R10: disabled, oscillator off target, code must not move
        check(int'(trim_code) == TRIM_INIT, "R10 frozen before enable", int'(trim_code), TRIM_INIT);
    endtask

    task automatic t_acquire;
        int prev;
        int cur;
        osc_base = 262.0;
        lock_en = 1'b1;
        prev = int'(trim_code);
        for (int k = 1; k <= WARM + LRUN + 1; k++) begin
            wait_ref(1);
            cur = int'(trim_code);
            check((cur - prev <= 1) && (prev - cur <= 1), "R3 one step per period", cur, prev);
            if (k >= 2) begin
                if (edges_of(prev) >= TARGET + 4.0)
                    check(cur == prev - 1, "R2 step down when fast", cur, prev - 1);
                else if (edges_of(prev) <= TARGET - 4.0)
                    check(cur == prev + 1, "R2 step up when slow", cur, prev + 1);
                else
                    check(cur == prev, "R2 hold inside deadband", cur, prev);
            end
            if (k <= WARM + 1)
                check(locked == 1'b0, "R5 no lock in warm-up", int'(locked), 0);
            else if (k < WARM + LRUN + 1)
                check(locked == 1'b0, "R6 no lock before run complete", int'(locked), 0);
            else
                check(locked == 1'b1, "R6 lock on fourth good period", int'(locked), 1);
            prev = cur;
        end
        check(int'(trim_code) == 11, "R2 settled code", int'(trim_code), 11);
    endtask

    task automatic t_outlier;
        osc_base = 292.0;
        wait_ref(1);
        osc_base = 262.0;
        check(locked == 1'b1, "R7 single outlier keeps lock", int'(locked), 1);
        wait_ref(1);
        check(locked == 1'b1, "R7 lock after recovery", int'(locked), 1);
        wait_ref(2);
    endtask

    task automatic t_unlock;
        bit got;
        osc_base = 290.0;
        wait_ref(1);
        check(locked == 1'b1, "R8 one bad period keeps lock", int'(locked), 1);
        wait_ref(1);
        check(locked == 1'b0, "R8 second bad period drops lock", int'(locked), 0);
        got = 1'b0;
        for (int k = 0; k < 20 && !got; k++) begin
            wait_ref(1);
            got = locked;
        end
        check(got, "R6 relock after shift", int'(got), 1);
        check(in_band(int'(trim_code)), "R6 relocked code in band", int'(trim_code), 4);
    endtask

    task automatic t_disable;
        int held;
        repeat (100) @(negedge clk);
        lock_en = 1'b0;
        #1;
        check(locked == 1'b0, "R9 lock cleared at once", int'(locked), 0);
        held = int'(trim_code);
        osc_base = 200.0;
        wait_ref(3);
        check(int'(trim_code) == held, "R10 code frozen while disabled", int'(trim_code), held);
        check(locked == 1'b0, "R9 stays unlocked while disabled", int'(locked), 0);
    endtask

    task automatic t_sat_low;
        osc_base = 340.0;
        lock_en = 1'b1;
        for (int k = 0; k < 14 && trim_code != '0; k++) wait_ref(1);
        wait_ref(3);
        check(trim_code == '0, "R4 saturate at zero", int'(trim_code), 0);
        check(locked == 1'b0, "R6 no lock when unreachable", int'(locked), 0);
    endtask

    task automatic t_sat_high;
        osc_base = 150.0;
        for (int k = 0; k < 40 && int'(trim_code) != TRIM_MAX; k++) wait_ref(1);
        wait_ref(3);
        check(int'(trim_code) == TRIM_MAX, "R4 saturate at top", int'(trim_code), TRIM_MAX);
        check(locked == 1'b0, "R6 no lock at top limit", int'(locked), 0);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_acquire();
        t_outlier();
        t_unlock();
        t_disable();
        t_sat_low();
        t_sat_high();
        finish_run();
    end

endmodule